// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block is a two-wire serial slave that lets a host processor read and write a small bank of 8-bit configuration registers. It oversamples the SCL and SDA lines with a fast system clock, recognises START and STOP conditions, and matches a 7-bit device address. Six bits of that address are fixed and the seventh comes from a strap input. SDA is driven open-drain: the block only ever pulls the line low, through an output enable. Every register is also presented in parallel on an output bus, so that the logic it configures reads it directly.

A write transfer carries the register index as its first byte after the address, and the data bytes follow it. A read transfer first loads the index with a short write phase. The master then issues a repeated START with the direction bit set and clocks data out of the slave. After each data byte the low four bits of the index step forward. The high four bits never change except through an index byte, so a burst stays inside one group of sixteen indices. Twelve registers exist: indices 0x00 to 0x08 and 0x10 to 0x12.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal 0,1,0,0,1,1 followed by the level on `addr_strap` (bit 0 of that byte is the direction: 0 write, 1 read). Any other address gets no acknowledge, and the bytes that follow it are ignored until the next START.
- R2: After a matching address byte, and after every index or data byte of a write, the slave pulls SDA low for the whole ninth clock.
- R3: In a write, the first byte after the address loads the index. Each following byte, shifted MSB first, is stored in the register at the current index and appears on `cfg_regs`.
- R4: After a repeated START with the direction bit set to 1, the slave shifts out the register at the current index, MSB first, one bit per SCL clock.
- R5: After every data byte written or read, index bits [3:0] increment and wrap from 0xF to 0x0. Bits [7:4] stay unchanged.
- R6: A write to an index outside 0x00–0x08 and 0x10–0x12 is acknowledged and discarded. A read from such an index returns 0x00.
- R7: When the master gives a no-acknowledge after a read byte, the slave releases SDA and drives nothing until the next START.
- R8: A STOP returns the slave to idle at any point. The index keeps its value, so a read that starts right after the STOP begins at the index where the last transfer ended.
- R9: The slave only starts pulling SDA low while SCL is low.
- R10: After reset, all registers read 0x00, the index is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 1 | Sets device address bit 0 |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| cfg_regs | output | 96 | Register contents. Byte n holds index n for n = 0..8; bytes 9..11 hold indices 0x10..0x12 |

## Verification
The assertions check on every cycle that the slave starts pulling SDA only with SCL low, that it never drives SDA while idle, that it drops SDA right after a STOP, and that the high index nibble changes only when an index byte is loaded. The bench scenarios cover what needs a whole transfer: address matching against the strap, acknowledge timing, the data stored and returned through single and burst transfers, the lower-nibble wrap, discarded writes to missing indices, the release after a master no-acknowledge, and the index kept across a STOP.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } phase_t;

  localparam logic [5:0] DEV_ADDR_HI = 6'b010011;
  localparam int unsigned CNT_W = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] scl_pipe;
  logic [W-1:0] sda_pipe;

  // Idle bus level is high, so the history starts high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[W-2:0], scl_i};
      sda_pipe <= {sda_pipe[W-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now   = scl_pipe[STAGES-1];
  assign scl_old   = scl_pipe[STAGES];
  assign sda_s     = sda_pipe[STAGES-1];
  assign sda_old   = sda_pipe[STAGES];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
  parameter int unsigned LO_COUNT = 9,
  parameter logic [7:0]  HI_BASE  = 8'h10,
  parameter int unsigned HI_COUNT = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [7:0]                           wr_idx,
  input  logic [7:0]                           wr_data,
  input  logic [7:0]                           rd_idx,
  output logic [7:0]                           rd_data,
  output logic [(LO_COUNT+HI_COUNT)*8-1:0]     regs_flat
);
  localparam int unsigned NREG = LO_COUNT + HI_COUNT;

  logic [7:0] sel_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [7:0] SLOT_IDX =
      (g < LO_COUNT) ? 8'(g) : 8'(int'(HI_BASE) + g - int'(LO_COUNT));
    logic [7:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && wr_idx == SLOT_IDX)   q <= wr_data;
    end

    assign regs_flat[g*8 +: 8] = q;
    assign sel_q[g] = (rd_idx == SLOT_IDX) ? q : 8'h00;
  end

  // Slot indices are distinct, so at most one term is non-zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) rd_data = rd_data | sel_q[i];
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int unsigned LO_COUNT    = 9,
  parameter logic [7:0]  HI_BASE     = 8'h10,
  parameter int unsigned HI_COUNT    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             addr_strap,
  input  logic                             scl_i,
  input  logic                             sda_i,
  output logic                             sda_oe,
  output logic [(LO_COUNT+HI_COUNT)*8-1:0] cfg_regs
);
  import i2c_cfg_pkg::*;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  phase_t           state, ack_next;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       idx;
  logic             mack;
  logic [7:0]       rd_data;
  logic             byte_end, wr_en, idx_load;
  logic [7:0]       next_idx;

  assign byte_end = scl_fall && (bitcnt == CNT_W'(8));
  assign wr_en    = (state == ST_WDATA) && byte_end && !start_det && !stop_det;
  assign idx_load = (state == ST_INDEX) && byte_end && !start_det && !stop_det;
  assign next_idx = {idx[7:4], idx[3:0] + 4'd1};

  i2c_cfg_regs #(
    .LO_COUNT(LO_COUNT),
    .HI_BASE (HI_BASE),
    .HI_COUNT(HI_COUNT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (idx),
    .wr_data  (shreg),
    .rd_idx   (idx),
    .rd_data  (rd_data),
    .regs_flat(cfg_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      idx      <= '0;
      sda_oe   <= 1'b0;
      mack     <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_INDEX, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + CNT_W'(1);
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == {DEV_ADDR_HI, addr_strap}) begin
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
                ack_next <= shreg[0] ? ST_RDATA : ST_INDEX;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe   <= 1'b1;
              state    <= ST_ACK;
              ack_next <= ST_WDATA;
              idx      <= (state == ST_INDEX) ? shreg : next_idx;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state  <= ack_next;
            bitcnt <= '0;
            if (ack_next == ST_RDATA) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + CNT_W'(1);
          end else if (byte_end) begin
            sda_oe <= 1'b0;
            idx    <= next_idx;
            state  <= ST_RACK;
            bitcnt <= '0;
          end else if (scl_fall) begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_chk.sv
module i2c_cfg_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_i,
  input logic                 sda_oe,
  input logic                 stop_det,
  input logic                 idx_load,
  input logic [7:0]           idx,
  input i2c_cfg_pkg::phase_t  state
);
  import i2c_cfg_pkg::*;

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (!scl_i && !$past(scl_i))); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R8

  AST_UPPER_NIBBLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((idx != $past(idx)) && !$past(idx_load)) |-> (idx[7:4] == $past(idx[7:4]))); // R5
endmodule

bind i2c_cfg_slave i2c_cfg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .stop_det(stop_det),
  .idx_load(idx_load),
  .idx     (idx),
  .state   (state)
);

// File: tb/test_i2c_cfg_slave.sv
`timescale 1ns/1ps
module test_i2c_cfg_slave;
  localparam int  NREG = 12;
  localparam time Q    = 50ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] cfg_regs;

  assign sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_cfg_slave i_i2c_cfg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_strap(strap),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .cfg_regs  (cfg_regs)
  );

  int n_chk = 0;
  int n_fail = 0;
  int pull_high = 0;
  logic [7:0] mdl [256];
  logic [7:0] wbuf [16];
  logic addr_x = 1'b1;

  // Stimulus table: {index, written byte, byte expected on read-back}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'hA5, 8'hA5},
    {8'h08, 8'h3C, 8'h3C},
    {8'h10, 8'h81, 8'h81},
    {8'h12, 8'h7E, 8'h7E},
    {8'h09, 8'hFF, 8'h00},
    {8'h20, 8'h55, 8'h00}
  };

  // R9 monitor: SDA pull may only begin while SCL is low
  logic oe_q = 1'b0;
  always @(posedge clk) begin
    if (sda_oe && !oe_q && scl) pull_high++;
    oe_q <= sda_oe;
  end

  function automatic int slot_of(input logic [7:0] ix);
    if (ix <= 8'h08) return int'(ix);
    if (ix >= 8'h10 && ix <= 8'h12) return 9 + int'(ix) - 16;
    return -1;
  endfunction

  function automatic logic [7:0] mdl_rd(input logic [7:0] ix);
    return (slot_of(ix) >= 0) ? mdl[ix] : 8'h00;
  endfunction

  function automatic logic [7:0] step(input logic [7:0] ix);
    return {ix[7:4], ix[3:0] + 4'd1};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; b = sda_line; #Q; scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = !b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!give_ack);
  endtask

  task automatic write_regs(input logic [7:0] ix, input int n, input string tag);
    logic a;
    logic [7:0] cur;
    cur = ix;
    bus_start();
    send_byte({6'b010011, addr_x, 1'b0}, a); check8("R2 addr ack", 8'(a), 8'h01);
    send_byte(ix, a);                        check8("R2 index ack", 8'(a), 8'h01);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      check8({tag, " data ack"}, 8'(a), 8'h01);
      if (slot_of(cur) >= 0) mdl[cur] = wbuf[i];
      cur = step(cur);
    end
    bus_stop();
  endtask

  task automatic read_regs(input logic [7:0] ix, input int n, input string tag);
    logic a;
    logic [7:0] d, cur;
    cur = ix;
    bus_start();
    send_byte({6'b010011, addr_x, 1'b0}, a); check8("R2 addr ack", 8'(a), 8'h01);
    send_byte(ix, a);                        check8("R2 index ack", 8'(a), 8'h01);
    bus_start();
    send_byte({6'b010011, addr_x, 1'b1}, a); check8("R1 read addr ack", 8'(a), 8'h01);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check8(tag, d, mdl_rd(cur));
      cur = step(cur);
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d, exp_slot;
    int s;
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    #20;

    // R10: reset state
    n_chk++;
    if (cfg_regs !== '0) begin
      n_fail++;
      $display("FAIL R10 regs: actual %h expected 0", cfg_regs);
    end
    check8("R10 sda released", 8'(sda_oe), 8'h00);

    // Table: single write then single read-back (R3, R4, R6)
    foreach (VEC[k]) begin
      wbuf[0] = VEC[k][15:8];
      write_regs(VEC[k][23:16], 1, "R3");
      read_regs(VEC[k][23:16], 1, "R4 R6 readback");
      check8("R6 table expect", mdl_rd(VEC[k][23:16]), VEC[k][7:0]);
      s = slot_of(VEC[k][23:16]);
      if (s >= 0) check8("R3 parallel out", cfg_regs[s*8 +: 8], VEC[k][7:0]);
    end

    // R3: burst write of all low-group registers
    for (int i = 0; i < 9; i++) wbuf[i] = 8'h11 + 8'(i);
    write_regs(8'h00, 9, "R3 burst");
    for (int i = 0; i < 9; i++) check8("R3 burst out", cfg_regs[i*8 +: 8], 8'h11 + 8'(i));

    // R5: wrap 0x0E -> 0x0F -> 0x00, no carry into 0x10
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    write_regs(8'h0E, 3, "R5 wrap");
    check8("R5 wrap to 0x00", cfg_regs[0 +: 8], 8'hC3);
    check8("R5 no carry", cfg_regs[9*8 +: 8], 8'h81);

    // R4/R5: burst read of high group and read across the wrap
    read_regs(8'h10, 3, "R4 burst read");
    read_regs(8'h1F, 2, "R5 read wrap");
    read_regs(8'h06, 4, "R4 R6 burst span");

    // R1: strap mismatch ignored
    strap = 1'b0;
    bus_start();
    send_byte({6'b010011, 1'b1, 1'b0}, a); check8("R1 mismatch nack", 8'(a), 8'h00);
    send_byte(8'h01, a);                   check8("R1 ignored index", 8'(a), 8'h00);
    send_byte(8'hEE, a);                   check8("R1 ignored data", 8'(a), 8'h00);
    bus_stop();
    check8("R1 reg unchanged", cfg_regs[1*8 +: 8], mdl[1]);
    addr_x = 1'b0;
    wbuf[0] = 8'h5A;
    write_regs(8'h02, 1, "R1 strap low");
    check8("R1 strap low write", cfg_regs[2*8 +: 8], 8'h5A);
    strap = 1'b1;
    addr_x = 1'b1;

    // R7: after master nack the slave stays off the line
    bus_start();
    send_byte({6'b010011, addr_x, 1'b0}, a);
    send_byte(8'h12, a);
    bus_start();
    send_byte({6'b010011, addr_x, 1'b1}, a);
    recv_byte(1'b0, d);
    check8("R7 last byte", d, mdl[8'h12]);
    recv_byte(1'b0, d);
    check8("R7 released after nack", d, 8'hFF);
    bus_stop();

    // R8: STOP keeps the index; read resumes there
    write_regs(8'h11, 0, "R8 index only");
    bus_start();
    send_byte({6'b010011, addr_x, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    check8("R8 read at kept index", d, mdl[8'h11]);

    bus_start();
    send_byte({6'b010011, addr_x, 1'b0}, a);
    send_byte(8'h05, a);
    send_byte(8'h99, a);
    bus_stop();
    mdl[8'h05] = 8'h99;
    check8("R8 write before stop", cfg_regs[5*8 +: 8], 8'h99);
    bus_start();
    send_byte({6'b010011, addr_x, 1'b1}, a);
    recv_byte(1'b0, d);
    bus_stop();
    check8("R8 index after stop", d, mdl[8'h06]);

    // R9: pull never begins with SCL high
    exp_slot = 8'h00;
    check8("R9 pull during scl high", 8'(pull_high), exp_slot);

    #200;
    finish_run();
  end
endmodule